// File: doc/BRIEF.md
# Banked Memory Window Selector

This unit sits beside an 8-bit CPU that sees only a 16-bit logical address space and maps it onto a 26-bit physical space. Three bank registers select the physical banks: program, interrupt and data. Each is 16 bits wide and is loaded one byte at a time through a small register port. A system control register holds an enable bit. When that bit is set and the CPU is servicing an interrupt, the interrupt bank takes the place of the program bank. Every logical address is sorted into a fixed region. For each access the unit then gives either an external physical address or an internal-RAM select with its RAM address.

The CPU raises `in_service` when it fetches an interrupt vector and drops it on return from interrupt. If bit 15 of the bank in use is set, the windowed access is sent to the upper 16 KB of internal RAM and not to external memory. Register writes take effect at the next clock edge. Translation is purely combinational from the register state and the logical address.

Top module: `mem_window_xlate`

## Requirements
- R1: `win_region` encodes the logical address as follows: 0 for 0x0000–0x007F, 1 for 0x0080–0x1FFF, 2 for 0x2000–0x3FFF, 3 for 0x4000–0x7FFF and 4 for 0x8000–0xFFFF. `ext_en` and `iram_en` are never both 1, and both are 0 in regions 0 and 4.
- R2: In region 1, `iram_en` is 1 and `iram_addr` equals logical address bits 14:0.
- R3: In region 3, when the bank in use has bit 15 clear, `ext_en` is 1 and `phys_addr` is {bank bits 11:0, logical bits 13:0}.
- R4: The region-3 bank is the interrupt bank only when `in_service` is 1 and system bit 1 is 1. In every other case it is the program bank.
- R5: In region 2 or 3, when the bank in use has bit 15 set, `iram_en` is 1 and `iram_addr` is 0x4000 OR logical bits 13:0.
- R6: In region 2, when the data bank has bit 15 clear, `ext_en` is 1 and `phys_addr` is {data bank bits 10:0, logical bits 14:0}.
- R7: Writes are masked. The program and interrupt banks keep the bits of mask 0x8FFF, and the data bank keeps the bits of mask 0x87FF. Readback shows the masked value.
- R8: Register selects on `reg_sel` are: 0/1 program low/high byte, 2/3 interrupt low/high, 4/5 data low/high and 6 system. A byte write leaves the other byte of the same bank unchanged.
- R9: Reading the system register returns bit 0 as 1. Stored bits are the written data ANDed with 0xFE.
- R10: Synchronous reset clears all bank registers and the system register. After reset the system register reads 0x01.
- R11: Select 7 reads as 0x00, and writing it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register byte write strobe |
| reg_sel | input | 3 | Register byte select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Readback of selected byte (combinational) |
| in_service | input | 1 | CPU is servicing an interrupt |
| cpu_addr | input | 16 | Logical address |
| win_region | output | 3 | Region code of cpu_addr |
| ext_en | output | 1 | Access goes to external memory |
| phys_addr | output | 26 | External physical address (0 when ext_en is 0) |
| iram_en | output | 1 | Access goes to internal RAM |
| iram_addr | output | 15 | Internal RAM address (0 when iram_en is 0) |

## Verification
The hardest case to reach is interrupt-bank selection, because it needs three conditions at once: `in_service` high, system bit 1 set, and an interrupt bank that differs from the program bank. The stimulus loads different values into the two banks. It then tries each of the four combinations of service flag and enable bit at one program-window address. Only the combination with both set may move the physical address. The bench also sets bit 15 in the interrupt bank alone, which shows that the redirect to internal RAM follows the selected bank and not the program bank.

// File: rtl/mwx_pkg.sv
// Shared types and constants for the banked memory window selector.
// Assumes a 16-bit logical space and 16-bit bank registers.
package mwx_pkg;

    typedef enum logic [2:0] {
        RGN_CTRL = 3'd0,
        RGN_IRAM = 3'd1,
        RGN_DATA = 3'd2,
        RGN_PROG = 3'd3,
        RGN_HIGH = 3'd4
    } region_t;

    localparam logic [2:0] SEL_PROG_LO = 3'd0;
    localparam logic [2:0] SEL_PROG_HI = 3'd1;
    localparam logic [2:0] SEL_IRQ_LO  = 3'd2;
    localparam logic [2:0] SEL_IRQ_HI  = 3'd3;
    localparam logic [2:0] SEL_DATA_LO = 3'd4;
    localparam logic [2:0] SEL_DATA_HI = 3'd5;
    localparam logic [2:0] SEL_SYS     = 3'd6;

    localparam logic [7:0] SYS_WR_MASK = 8'hFE;
    localparam int         SYS_IRQ_EN_BIT = 1;

    // Keep bit 15 plus (phys_aw - ofs_w) low bits.
    function automatic logic [15:0] bank_mask(input int phys_aw, input int ofs_w);
        logic [15:0] m;
        m = 16'h8000;
        for (int b = 0; b < 15; b++) begin
            if (b < phys_aw - ofs_w) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/mwx_bank_reg.sv
// One 16-bit bank register loaded a byte at a time.
// Assumes LO_SEL and HI_SEL are distinct; bits outside MASK always read 0.
module mwx_bank_reg #(
    parameter logic [15:0] MASK   = 16'hFFFF,
    parameter logic [2:0]  LO_SEL = 3'd0,
    parameter logic [2:0]  HI_SEL = 3'd1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [7:0]  wr_data,
    output logic [15:0] bank_q
);

    // Byte-wise masked load; the other byte holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (wr_en && wr_sel == LO_SEL) begin
            bank_q[7:0] <= wr_data & MASK[7:0];
        end else if (wr_en && wr_sel == HI_SEL) begin
            bank_q[15:8] <= wr_data & MASK[15:8];
        end
    end

endmodule

// File: rtl/mwx_sys_reg.sv
// System control register: holds the interrupt-bank enable.
// Assumes bit 0 is not storable and always reads as 1.
module mwx_sys_reg
    import mwx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_value,
    output logic       irq_bank_en
);

    logic [7:0] sys_q;

    // Masked load of the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_q <= '0;
        end else if (wr_en && wr_sel == SEL_SYS) begin
            sys_q <= wr_data & SYS_WR_MASK;
        end
    end

    // Readback forces bit 0; the enable is a single stored bit.
    always_comb begin
        rd_value    = sys_q | 8'h01;
        irq_bank_en = sys_q[SYS_IRQ_EN_BIT];
    end

endmodule

// File: rtl/mwx_region_dec.sv
// Sorts a logical address into one of five fixed regions.
// Assumes the window limits below are fixed by the CPU's memory layout.
module mwx_region_dec
    import mwx_pkg::*;
(
    input  logic [15:0] cpu_addr,
    output region_t     region
);

    // Compare against ascending region limits.
    always_comb begin
        if (cpu_addr < 16'h0080)      region = RGN_CTRL;
        else if (cpu_addr < 16'h2000) region = RGN_IRAM;
        else if (cpu_addr < 16'h4000) region = RGN_DATA;
        else if (cpu_addr < 16'h8000) region = RGN_PROG;
        else                          region = RGN_HIGH;
    end

endmodule

// File: rtl/mwx_xlate.sv
// Picks the bank for the current region and forms the target address.
// Assumes bank numbers arrive already masked and split from their RAM flag.
module mwx_xlate
    import mwx_pkg::*;
#(
    parameter int PHYS_AW    = 26,
    parameter int IRAM_AW    = 15,
    parameter int PROG_OFS_W = 14,
    parameter int DATA_OFS_W = 15,
    localparam int PBW = PHYS_AW - PROG_OFS_W,
    localparam int DBW = PHYS_AW - DATA_OFS_W
) (
    input  region_t              region,
    input  logic [DATA_OFS_W-1:0] ofs,
    input  logic [PBW-1:0]       prog_num,
    input  logic                 prog_to_iram,
    input  logic [PBW-1:0]       irq_num,
    input  logic                 irq_to_iram,
    input  logic [DBW-1:0]       data_num,
    input  logic                 data_to_iram,
    input  logic                 in_service,
    input  logic                 irq_bank_en,
    output logic                 ext_en,
    output logic [PHYS_AW-1:0]   phys_addr,
    output logic                 iram_en,
    output logic [IRAM_AW-1:0]   iram_addr
);

    localparam logic [IRAM_AW-1:0] IRAM_WIN_BASE = IRAM_AW'(16'h4000);

    logic           use_irq;
    logic [PBW-1:0] pwin_num;
    logic           pwin_iram;
    logic [IRAM_AW-1:0] banked_iram;

    // Interrupt bank overrides only with both service flag and enable.
    always_comb begin
        use_irq     = in_service && irq_bank_en;
        pwin_num    = use_irq ? irq_num : prog_num;
        pwin_iram   = use_irq ? irq_to_iram : prog_to_iram;
        banked_iram = IRAM_WIN_BASE | IRAM_AW'(ofs[PROG_OFS_W-1:0]);
    end

    // Route the access per region.
    always_comb begin
        ext_en    = 1'b0;
        iram_en   = 1'b0;
        phys_addr = '0;
        iram_addr = '0;
        unique case (region)
            RGN_IRAM: begin
                iram_en   = 1'b1;
                iram_addr = ofs[IRAM_AW-1:0];
            end
            RGN_DATA: begin
                if (data_to_iram) begin
                    iram_en   = 1'b1;
                    iram_addr = banked_iram;
                end else begin
                    ext_en    = 1'b1;
                    phys_addr = {data_num, ofs[DATA_OFS_W-1:0]};
                end
            end
            RGN_PROG: begin
                if (pwin_iram) begin
                    iram_en   = 1'b1;
                    iram_addr = banked_iram;
                end else begin
                    ext_en    = 1'b1;
                    phys_addr = {pwin_num, ofs[PROG_OFS_W-1:0]};
                end
            end
            default: begin
                ext_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mem_window_xlate.sv
// Top of the banked memory window selector: bank registers, system
// register, region decode and address formation.
// Assumes PHYS_AW - PROG_OFS_W <= 15 and IRAM_AW = DATA_OFS_W.
module mem_window_xlate
    import mwx_pkg::*;
#(
    parameter int PHYS_AW    = 26,
    parameter int IRAM_AW    = 15,
    parameter int PROG_OFS_W = 14,
    parameter int DATA_OFS_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [2:0]         reg_sel,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               in_service,
    input  logic [15:0]        cpu_addr,
    output logic [2:0]         win_region,
    output logic               ext_en,
    output logic [PHYS_AW-1:0] phys_addr,
    output logic               iram_en,
    output logic [IRAM_AW-1:0] iram_addr
);

    localparam int NUM_BANKS = 3;
    localparam int BANK_PROG = 0;
    localparam int BANK_IRQ  = 1;
    localparam int BANK_DATA = 2;
    localparam int PBW = PHYS_AW - PROG_OFS_W;
    localparam int DBW = PHYS_AW - DATA_OFS_W;

    logic [15:0] bank_q [NUM_BANKS];
    logic [15:0] prog_bank_q;
    logic [15:0] irq_bank_q;
    logic [15:0] data_bank_q;
    logic [7:0]  sys_rd;
    logic        irq_bank_en;
    region_t     region;

    // One register per bank; the data bank has the wider offset.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam int          OFS_W  = (g == BANK_DATA) ? DATA_OFS_W : PROG_OFS_W;
        localparam logic [15:0] MASK   = bank_mask(PHYS_AW, OFS_W);
        localparam logic [2:0]  LO_SEL = 3'(2 * g);
        localparam logic [2:0]  HI_SEL = 3'(2 * g + 1);
        mwx_bank_reg #(
            .MASK   (MASK),
            .LO_SEL (LO_SEL),
            .HI_SEL (HI_SEL)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_wr_en),
            .wr_sel  (reg_sel),
            .wr_data (reg_wdata),
            .bank_q  (bank_q[g])
        );
    end

    // Named views of the bank array.
    always_comb begin
        prog_bank_q = bank_q[BANK_PROG];
        irq_bank_q  = bank_q[BANK_IRQ];
        data_bank_q = bank_q[BANK_DATA];
    end

    mwx_sys_reg u_sys (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .wr_sel      (reg_sel),
        .wr_data     (reg_wdata),
        .rd_value    (sys_rd),
        .irq_bank_en (irq_bank_en)
    );

    mwx_region_dec u_dec (
        .cpu_addr (cpu_addr),
        .region   (region)
    );

    mwx_xlate #(
        .PHYS_AW    (PHYS_AW),
        .IRAM_AW    (IRAM_AW),
        .PROG_OFS_W (PROG_OFS_W),
        .DATA_OFS_W (DATA_OFS_W)
    ) u_xlate (
        .region       (region),
        .ofs          (cpu_addr[DATA_OFS_W-1:0]),
        .prog_num     (prog_bank_q[PBW-1:0]),
        .prog_to_iram (prog_bank_q[15]),
        .irq_num      (irq_bank_q[PBW-1:0]),
        .irq_to_iram  (irq_bank_q[15]),
        .data_num     (data_bank_q[DBW-1:0]),
        .data_to_iram (data_bank_q[15]),
        .in_service   (in_service),
        .irq_bank_en  (irq_bank_en),
        .ext_en       (ext_en),
        .phys_addr    (phys_addr),
        .iram_en      (iram_en),
        .iram_addr    (iram_addr)
    );

    // Region code out of the decoder.
    always_comb win_region = region;

    // Byte readback multiplexer.
    always_comb begin
        case (reg_sel)
            SEL_PROG_LO: reg_rdata = prog_bank_q[7:0];
            SEL_PROG_HI: reg_rdata = prog_bank_q[15:8];
            SEL_IRQ_LO:  reg_rdata = irq_bank_q[7:0];
            SEL_IRQ_HI:  reg_rdata = irq_bank_q[15:8];
            SEL_DATA_LO: reg_rdata = data_bank_q[7:0];
            SEL_DATA_HI: reg_rdata = data_bank_q[15:8];
            SEL_SYS:     reg_rdata = sys_rd;
            default:     reg_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/mwx_checks.sv
// Property checker for the window selector, bound to the top module.
module mwx_checks
    import mwx_pkg::*;
#(
    parameter int PHYS_AW    = 26,
    parameter int PROG_OFS_W = 14,
    parameter int DATA_OFS_W = 15,
    parameter int IRAM_AW    = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr_en,
    input logic [2:0]         reg_sel,
    input logic [7:0]         reg_rdata,
    input logic               in_service,
    input logic [15:0]        cpu_addr,
    input logic [2:0]         win_region,
    input logic               ext_en,
    input logic [PHYS_AW-1:0] phys_addr,
    input logic               iram_en,
    input logic [IRAM_AW-1:0] iram_addr,
    input logic [15:0]        prog_bank_q,
    input logic [15:0]        data_bank_q
);

    localparam int PBW = PHYS_AW - PROG_OFS_W;
    localparam logic [15:0] PMASK = bank_mask(PHYS_AW, PROG_OFS_W);
    localparam logic [15:0] DMASK = bank_mask(PHYS_AW, DATA_OFS_W);

    a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_en, iram_en}));

    a_r1_quiet_regions: assert property (@(posedge clk) disable iff (!rst_n)
        (win_region == RGN_CTRL || win_region == RGN_HIGH) |-> (!ext_en && !iram_en));

    a_r2_direct_iram: assert property (@(posedge clk) disable iff (!rst_n)
        (win_region == RGN_IRAM) |-> (iram_en && iram_addr == cpu_addr[IRAM_AW-1:0]));

    // R4: outside service the program bank drives the program window
    a_r4_prog_outside_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (win_region == RGN_PROG && !in_service && !prog_bank_q[15])
        |-> (ext_en && phys_addr[PHYS_AW-1:PROG_OFS_W] == prog_bank_q[PBW-1:0]));

    a_r7_prog_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_bank_q & ~PMASK) == 16'h0000);

    a_r7_data_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (data_bank_q & ~DMASK) == 16'h0000);

    a_r8_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_sel == SEL_PROG_LO) |=> (prog_bank_q[15:8] == $past(prog_bank_q[15:8])));

    a_r9_sys_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_SYS) |-> reg_rdata[0]);

endmodule

bind mem_window_xlate mwx_checks #(
    .PHYS_AW    (PHYS_AW),
    .PROG_OFS_W (PROG_OFS_W),
    .DATA_OFS_W (DATA_OFS_W),
    .IRAM_AW    (IRAM_AW)
) u_mwx_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_sel     (reg_sel),
    .reg_rdata   (reg_rdata),
    .in_service  (in_service),
    .cpu_addr    (cpu_addr),
    .win_region  (win_region),
    .ext_en      (ext_en),
    .phys_addr   (phys_addr),
    .iram_en     (iram_en),
    .iram_addr   (iram_addr),
    .prog_bank_q (prog_bank_q),
    .data_bank_q (data_bank_q)
);

// File: tb/mem_window_xlate_test.sv
// Scoreboard bench: driver tasks queue expected results, a monitor compares.
module mem_window_xlate_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        in_service = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [2:0]  win_region;
    logic        ext_en;
    logic [25:0] phys_addr;
    logic        iram_en;
    logic [14:0] iram_addr;

    mem_window_xlate uut (
        .clk (clk), .rst_n (rst_n), .reg_wr_en (reg_wr_en), .reg_sel (reg_sel),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .in_service (in_service),
        .cpu_addr (cpu_addr), .win_region (win_region), .ext_en (ext_en),
        .phys_addr (phys_addr), .iram_en (iram_en), .iram_addr (iram_addr)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        bit          is_read;
        logic [7:0]  rdata;
        logic [2:0]  region;
        logic        ext;
        logic [25:0] phys;
        logic        iram;
        logic [14:0] iaddr;
        string       tag;
    } exp_t;

    exp_t  sb_q[$];
    event  chk_ev;
    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;

    // Bench model of the register state, from the requirements.
    logic [15:0] m_prog = 0, m_irq = 0, m_data = 0;
    logic [7:0]  m_sys = 0;

    // Monitor: pops one expected item per trigger and compares.
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (e.is_read) begin
                    if (reg_rdata !== e.rdata) begin
                        n_fail++;
                        $display("FAIL %s: rdata actual %h expected %h", e.tag, reg_rdata, e.rdata);
                    end
                end else if (win_region !== e.region || ext_en !== e.ext || phys_addr !== e.phys
                             || iram_en !== e.iram || iram_addr !== e.iaddr) begin
                    n_fail++;
                    $display("FAIL %s: actual rgn=%0d ext=%b phys=%h iram=%b ia=%h expected rgn=%0d ext=%b phys=%h iram=%b ia=%h",
                             e.tag, win_region, ext_en, phys_addr, iram_en, iram_addr,
                             e.region, e.ext, e.phys, e.iram, e.iaddr);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_prog = 0; m_irq = 0; m_data = 0; m_sys = 0;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        case (sel)
            3'd0: m_prog[7:0]  = d;
            3'd1: m_prog[15:8] = d & 8'h8F;
            3'd2: m_irq[7:0]   = d;
            3'd3: m_irq[15:8]  = d & 8'h8F;
            3'd4: m_data[7:0]  = d;
            3'd5: m_data[15:8] = d & 8'h87;
            3'd6: m_sys        = d & 8'hFE;
            default: ;
        endcase
    endtask

    function automatic logic [7:0] model_read(input logic [2:0] sel);
        case (sel)
            3'd0: return m_prog[7:0];
            3'd1: return m_prog[15:8];
            3'd2: return m_irq[7:0];
            3'd3: return m_irq[15:8];
            3'd4: return m_data[7:0];
            3'd5: return m_data[15:8];
            3'd6: return m_sys | 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk_read(input logic [2:0] sel, input string tag);
        exp_t e;
        @(negedge clk);
        reg_sel = sel;
        e.is_read = 1; e.rdata = model_read(sel); e.region = 0; e.ext = 0;
        e.phys = 0; e.iram = 0; e.iaddr = 0; e.tag = tag;
        sb_q.push_back(e);
        ->chk_ev;
    endtask

    task automatic chk_xlate(input logic [15:0] a, input logic isr, input string tag);
        exp_t e;
        logic [15:0] bk;
        @(negedge clk);
        cpu_addr = a; in_service = isr;
        e.is_read = 0; e.rdata = 0; e.ext = 0; e.phys = 0; e.iram = 0; e.iaddr = 0; e.tag = tag;
        if (a < 16'h0080)      e.region = 3'd0;
        else if (a < 16'h2000) e.region = 3'd1;
        else if (a < 16'h4000) e.region = 3'd2;
        else if (a < 16'h8000) e.region = 3'd3;
        else                   e.region = 3'd4;
        if (e.region == 3'd1) begin
            e.iram = 1; e.iaddr = a[14:0];
        end else if (e.region == 3'd2 || e.region == 3'd3) begin
            bk = (e.region == 3'd2) ? m_data : ((isr && m_sys[1]) ? m_irq : m_prog);
            if (bk[15]) begin
                e.iram = 1; e.iaddr = 15'h4000 | {1'b0, a[13:0]};
            end else begin
                e.ext = 1;
                e.phys = (e.region == 3'd2) ? {bk[10:0], a[14:0]} : {bk[11:0], a[13:0]};
            end
        end
        sb_q.push_back(e);
        ->chk_ev;
    endtask

    // Watchdog: expiry counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10: reset state of every select
        for (int s = 0; s < 8; s++) chk_read(3'(s), "R10 reset readback");

        // R1 / R2 / R3 / R6 with zero banks
        chk_xlate(16'h0010, 1'b0, "R1 control region");
        chk_xlate(16'h0080, 1'b0, "R2 direct iram low edge");
        chk_xlate(16'h1FFF, 1'b0, "R2 direct iram high edge");
        chk_xlate(16'h2000, 1'b0, "R6 data window bank 0");
        chk_xlate(16'h4000, 1'b0, "R3 program window bank 0");
        chk_xlate(16'h7FFF, 1'b0, "R3 program window top");
        chk_xlate(16'h8000, 1'b0, "R1 high region");
        chk_xlate(16'hFFFF, 1'b0, "R1 high region top");

        // R7 masks, R5 redirect on program bank
        wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
        chk_read(3'd0, "R7 prog low");
        chk_read(3'd1, "R7 prog high masked");
        chk_xlate(16'h4123, 1'b0, "R5 program to iram");

        // R8 byte preservation, R3 nonzero bank
        wr(3'd1, 8'h0A);
        chk_read(3'd0, "R8 prog low kept");
        chk_read(3'd1, "R8 prog high");
        chk_xlate(16'h5ABC, 1'b0, "R3 program bank 0x0AFF");

        // R4 interrupt bank selection across all four combinations
        wr(3'd2, 8'h23); wr(3'd3, 8'h01);
        chk_read(3'd3, "R8 irq high");
        chk_xlate(16'h6001, 1'b1, "R4 service without enable");
        wr(3'd6, 8'hFF);
        chk_read(3'd6, "R9 sys all ones");
        wr(3'd6, 8'h02);
        chk_read(3'd6, "R9 sys bit0 forced");
        chk_xlate(16'h6001, 1'b1, "R4 service with enable");
        chk_xlate(16'h6001, 1'b0, "R4 enable without service");
        wr(3'd6, 8'h01);
        chk_read(3'd6, "R9 sys write bit0 only");
        chk_xlate(16'h6001, 1'b0, "R4 neither");
        chk_xlate(16'h6001, 1'b1, "R4 service after disable");

        // R5 redirect follows the interrupt bank
        wr(3'd6, 8'h02);
        wr(3'd3, 8'hFF);
        chk_read(3'd3, "R7 irq high masked");
        chk_xlate(16'h4ABC, 1'b1, "R5 interrupt bank to iram");
        chk_xlate(16'h4ABC, 1'b0, "R5 program bank outside service");

        // R6 / R7 / R5 data window
        wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
        chk_read(3'd5, "R7 data high masked");
        chk_xlate(16'h2345, 1'b0, "R5 data to iram");
        wr(3'd5, 8'h05);
        chk_read(3'd4, "R8 data low kept");
        chk_xlate(16'h3FFF, 1'b0, "R6 data bank 0x05FF");

        // R11 unused select
        wr(3'd7, 8'hFF);
        for (int s = 0; s < 8; s++) chk_read(3'(s), "R11 readback after select 7");
        chk_xlate(16'h3FFF, 1'b0, "R11 data window unchanged");

        // R10 reset mid-run
        do_reset();
        for (int s = 0; s < 7; s++) chk_read(3'(s), "R10 second reset");
        chk_xlate(16'h4ABC, 1'b1, "R10 program bank 0 after reset");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule